// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block looks after the low-power state of a small microcontroller. When the core asks to halt, the block stops the system clock by lowering a clock enable. It enters Idle or Sleep according to a mode bit sampled at that moment. While halted it watches four kinds of wake event: an external reset, a falling edge on any enabled pin of an 8-bit port, a fresh interrupt request, and a watchdog overflow.

When a wake event arrives, the block turns the system clock back on at once. It then counts a fixed start-up period in system clocks. At the end of that period it sends the core one of four one-cycle commands: full reset, partial reset (program counter and stack pointer only), take the interrupt vector, or resume at the instruction after the halt. Two sticky status flags, power-down and time-out, let software work out afterwards why the core woke.

The block's own clock never stops. Only the system clock is gated, through the `sysClkEn` output. Port pins are synchronized in the always-on domain, so an edge can be seen while the core is stopped.

Top module: `halt_wake_unit`

## Requirements
- R1: A `haltReq` pulse in the running state lowers `sysClkEn` from the next cycle. While halted, exactly one of `inIdle` (when `idleMode` was 1 at entry) or `inSleep` (when it was 0) is high. A `haltReq` outside the running state has no effect.
- R2: Halt entry sets `pdFlag` to 1 and clears `toFlag` to 0 in the same cycle.
- R3: Both flags are 0 after power-on reset. A `clrWdtCmd` pulse clears `pdFlag`. Only halt entry sets it.
- R4: When `wdtFromSlow` is 1, `wdtClear` pulses in the cycle the halt is accepted and `wdtRun` stays high while halted. When `wdtFromSlow` is 0, `wdtRun` is low for the whole halt.
- R5: A `wdtOverflow` while halted with `wdtFromSlow`=1 sets `toFlag` and ends in a `wakePartial` command. With `wdtFromSlow`=0, an overflow while halted is ignored.
- R6: An `extReset` pulse while halted ends in a `wakeFull` command. Both flags keep their values.
- R7: A falling edge on port bit i while `portWakeEn[i]`=1 wakes the block and ends in `wakeResume`. An edge on a bit whose enable is 0 does not wake it.
- R8: A new interrupt request wakes the block. If at least one woken request has its `irqEn` bit set and `stackFull` is 0, the result is `wakeVector`. Otherwise the result is `wakeResume`, and the request stays asserted at the input.
- R9: An `irqReq` bit that was already high in the cycle the halt was accepted cannot wake the block during that halt.
- R10: `sysClkEn` rises in the cycle after the wake event. The reset and resume commands pulse in the STARTUP_CYCLES-th cycle with `sysClkEn` high. `wakeVector` pulses one cycle later. At most one command pulses in any cycle.
- R11: When wake sources coincide, the order of precedence is external reset, then watchdog overflow, then interrupt, then port edge. The losing sources leave no trace, so `toFlag` is not set when a reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the block |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| haltReq | input | 1 | Halt request pulse from the core |
| idleMode | input | 1 | 1 selects Idle, 0 selects Sleep |
| clrWdtCmd | input | 1 | Clear-watchdog command pulse |
| wdtFromSlow | input | 1 | Watchdog runs from the low-speed clock |
| wdtOverflow | input | 1 | Watchdog overflow pulse |
| extReset | input | 1 | External reset pulse |
| portIn | input | PORT_W | Port pin levels, asynchronous |
| portWakeEn | input | PORT_W | Per-pin falling-edge wake enable |
| irqReq | input | IRQ_W | Interrupt request flags |
| irqEn | input | IRQ_W | Interrupt enable bits |
| stackFull | input | 1 | Core stack has no free level |
| sysClkEn | output | 1 | System clock enable |
| inSleep | output | 1 | Halted in Sleep |
| inIdle | output | 1 | Halted in Idle |
| wdtClear | output | 1 | Clears the watchdog on halt entry |
| wdtRun | output | 1 | Watchdog count enable |
| pdFlag | output | 1 | Power-down status flag |
| toFlag | output | 1 | Time-out status flag |
| wakeFull | output | 1 | Command: full system reset |
| wakePartial | output | 1 | Command: reset program counter and stack pointer |
| wakeVector | output | 1 | Command: take the interrupt vector |
| wakeResume | output | 1 | Command: resume after the halt |

## Verification
The bench targets requests that must not wake the block: an edge on a port pin without wake enable, an interrupt already pending when the halt was taken, and an overflow from a watchdog that stopped with the system clock. A design that got any of these wrong would leave the halt early and issue a command the scoreboard does not expect. It also checks how an interrupt wake is resolved when the interrupt is disabled or the stack is full; a design that ignored those inputs would issue a vector command instead of resume. Coincident sources are used to test the order of precedence, where a wrong order gives the wrong command or leaves a stray time-out flag. Every command is timed against the start-up count, so an off-by-one counter, or a vector command that lacks its extra cycle, shows up as a wrong cycle number.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_HALT,
    ST_WARM,
    ST_EXTRA
  } pwrState_t;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_FULL,
    WK_PARTIAL,
    WK_VECTOR,
    WK_RESUME
  } wakeKind_t;

  typedef struct packed {
    logic enterHalt;
    logic setTimeout;
  } ctrlStrobe_t;

endpackage

// File: rtl/halt_wake_datapath.sv
module halt_wake_datapath
  import halt_wake_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              clrWdtCmd,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] portWakeEn,
  input  logic [IRQ_W-1:0]  irqReq,
  input  logic [IRQ_W-1:0]  irqEn,
  input  logic              stackFull,
  output logic              portWake,
  output logic              irqWake,
  output logic              irqVector,
  output logic              pdFlag,
  output logic              toFlag
);

  logic [PORT_W-1:0] pinFall;
  logic [IRQ_W-1:0]  pendMask;
  logic [IRQ_W-1:0]  freshIrq;

  // per-pin two-flop synchronizer plus previous-level flop
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic syncA, syncB, prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA   <= 1'b1;
        syncB   <= 1'b1;
        prevLvl <= 1'b1;
      end else begin
        syncA   <= portIn[i];
        syncB   <= syncA;
        prevLvl <= syncB;
      end
    end
    assign pinFall[i] = prevLvl & ~syncB & portWakeEn[i];
  end

  assign portWake = |pinFall;

  // requests already raised at halt entry are masked for that halt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
    end else if (strobe.enterHalt) begin
      pendMask <= irqReq;
    end
  end

  assign freshIrq  = irqReq & ~pendMask;
  assign irqWake   = |freshIrq;
  assign irqVector = (|(freshIrq & irqEn)) & ~stackFull;

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdFlag <= 1'b0;
      toFlag <= 1'b0;
    end else begin
      if (strobe.enterHalt) begin
        pdFlag <= 1'b1;
      end else if (clrWdtCmd) begin
        pdFlag <= 1'b0;
      end
      if (strobe.enterHalt) begin
        toFlag <= 1'b0;
      end else if (strobe.setTimeout) begin
        toFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int STARTUP_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltReq,
  input  logic        idleMode,
  input  logic        wdtFromSlow,
  input  logic        wdtOverflow,
  input  logic        extReset,
  input  logic        portWake,
  input  logic        irqWake,
  input  logic        irqVector,
  output ctrlStrobe_t strobe,
  output logic        sysClkEn,
  output logic        inSleep,
  output logic        inIdle,
  output logic        wdtClear,
  output logic        wdtRun,
  output logic        wakeFull,
  output logic        wakePartial,
  output logic        wakeVector,
  output logic        wakeResume
);

  localparam int CNT_W = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STARTUP_CYCLES - 1);

  pwrState_t        state;
  wakeKind_t        cause;
  wakeKind_t        wakeSel;
  logic [CNT_W-1:0] warmCnt;
  logic             idleLat;
  logic             warmDone;

  // fixed precedence among coincident wake sources
  always_comb begin
    if (extReset) begin
      wakeSel = WK_FULL;
    end else if (wdtOverflow && wdtFromSlow) begin
      wakeSel = WK_PARTIAL;
    end else if (irqWake) begin
      wakeSel = irqVector ? WK_VECTOR : WK_RESUME;
    end else if (portWake) begin
      wakeSel = WK_RESUME;
    end else begin
      wakeSel = WK_NONE;
    end
  end

  assign warmDone = (state == ST_WARM) && (warmCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      cause   <= WK_NONE;
      warmCnt <= '0;
      idleLat <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (haltReq) begin
            state   <= ST_HALT;
            idleLat <= idleMode;
          end
        end
        ST_HALT: begin
          if (wakeSel != WK_NONE) begin
            state   <= ST_WARM;
            cause   <= wakeSel;
            warmCnt <= '0;
          end
        end
        ST_WARM: begin
          if (warmDone) begin
            state <= (cause == WK_VECTOR) ? ST_EXTRA : ST_RUN;
          end else begin
            warmCnt <= warmCnt + 1'b1;
          end
        end
        ST_EXTRA: begin
          state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.enterHalt  = (state == ST_RUN) && haltReq;
    strobe.setTimeout = (state == ST_HALT) && (wakeSel == WK_PARTIAL);
  end

  assign sysClkEn    = (state != ST_HALT);
  assign inSleep     = (state == ST_HALT) && !idleLat;
  assign inIdle      = (state == ST_HALT) && idleLat;
  assign wdtClear    = strobe.enterHalt && wdtFromSlow;
  assign wdtRun      = (state != ST_HALT) || wdtFromSlow;
  assign wakeFull    = warmDone && (cause == WK_FULL);
  assign wakePartial = warmDone && (cause == WK_PARTIAL);
  assign wakeResume  = warmDone && (cause == WK_RESUME);
  assign wakeVector  = (state == ST_EXTRA);

endmodule

// File: rtl/halt_wake_unit.sv
module halt_wake_unit
  import halt_wake_pkg::*;
#(
  parameter int PORT_W         = 8,
  parameter int IRQ_W          = 4,
  parameter int STARTUP_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  input  logic              idleMode,
  input  logic              clrWdtCmd,
  input  logic              wdtFromSlow,
  input  logic              wdtOverflow,
  input  logic              extReset,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] portWakeEn,
  input  logic [IRQ_W-1:0]  irqReq,
  input  logic [IRQ_W-1:0]  irqEn,
  input  logic              stackFull,
  output logic              sysClkEn,
  output logic              inSleep,
  output logic              inIdle,
  output logic              wdtClear,
  output logic              wdtRun,
  output logic              pdFlag,
  output logic              toFlag,
  output logic              wakeFull,
  output logic              wakePartial,
  output logic              wakeVector,
  output logic              wakeResume
);

  ctrlStrobe_t strobe;
  logic        portWake;
  logic        irqWake;
  logic        irqVector;

  halt_wake_ctrl #(
    .STARTUP_CYCLES(STARTUP_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .haltReq    (haltReq),
    .idleMode   (idleMode),
    .wdtFromSlow(wdtFromSlow),
    .wdtOverflow(wdtOverflow),
    .extReset   (extReset),
    .portWake   (portWake),
    .irqWake    (irqWake),
    .irqVector  (irqVector),
    .strobe     (strobe),
    .sysClkEn   (sysClkEn),
    .inSleep    (inSleep),
    .inIdle     (inIdle),
    .wdtClear   (wdtClear),
    .wdtRun     (wdtRun),
    .wakeFull   (wakeFull),
    .wakePartial(wakePartial),
    .wakeVector (wakeVector),
    .wakeResume (wakeResume)
  );

  halt_wake_datapath #(
    .PORT_W(PORT_W),
    .IRQ_W (IRQ_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .clrWdtCmd (clrWdtCmd),
    .portIn    (portIn),
    .portWakeEn(portWakeEn),
    .irqReq    (irqReq),
    .irqEn     (irqEn),
    .stackFull (stackFull),
    .portWake  (portWake),
    .irqWake   (irqWake),
    .irqVector (irqVector),
    .pdFlag    (pdFlag),
    .toFlag    (toFlag)
  );

endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk (
  input logic clk,
  input logic rstN,
  input logic sysClkEn,
  input logic inSleep,
  input logic inIdle,
  input logic wdtFromSlow,
  input logic wdtRun,
  input logic pdFlag,
  input logic toFlag,
  input logic wakeFull,
  input logic wakePartial,
  input logic wakeVector,
  input logic wakeResume
);

  // R1
  halt_mode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysClkEn |-> (inSleep ^ inIdle));

  // R1
  run_no_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysClkEn |-> !(inSleep || inIdle));

  // R2
  entry_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysClkEn) |-> (pdFlag && !toFlag));

  // R3
  pd_set_only_on_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdFlag) |-> $fell(sysClkEn));

  // R4
  wdt_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sysClkEn && !wdtFromSlow) |-> !wdtRun);

  // R5
  partial_has_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePartial |-> toFlag);

  // R10
  single_command_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wakeFull, wakePartial, wakeVector, wakeResume}));

  // R10
  command_clock_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFull || wakePartial || wakeVector || wakeResume) |-> sysClkEn);

endmodule

bind halt_wake_unit halt_wake_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sysClkEn   (sysClkEn),
  .inSleep    (inSleep),
  .inIdle     (inIdle),
  .wdtFromSlow(wdtFromSlow),
  .wdtRun     (wdtRun),
  .pdFlag     (pdFlag),
  .toFlag     (toFlag),
  .wakeFull   (wakeFull),
  .wakePartial(wakePartial),
  .wakeVector (wakeVector),
  .wakeResume (wakeResume)
);

// File: tb/halt_wake_unit_tb.sv
`timescale 1ns/1ps
module halt_wake_unit_tb;

  localparam int PW = 8;
  localparam int IW = 4;
  localparam int SC = 8;
  localparam int K_FULL = 0, K_PART = 1, K_VEC = 2, K_RES = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b0, idleMode = 1'b0, clrWdtCmd = 1'b0;
  logic wdtFromSlow = 1'b1, wdtOverflow = 1'b0, extReset = 1'b0;
  logic [PW-1:0] portIn = '1, portWakeEn = '0;
  logic [IW-1:0] irqReq = '0, irqEn = '0;
  logic stackFull = 1'b0;
  logic sysClkEn, inSleep, inIdle, wdtClear, wdtRun, pdFlag, toFlag;
  logic wakeFull, wakePartial, wakeVector, wakeResume;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  int onCyc = 0;
  bit clrSeen;

  always #5 clk = ~clk;

  halt_wake_unit #(.PORT_W(PW), .IRQ_W(IW), .STARTUP_CYCLES(SC)) u_dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .idleMode(idleMode),
    .clrWdtCmd(clrWdtCmd), .wdtFromSlow(wdtFromSlow), .wdtOverflow(wdtOverflow),
    .extReset(extReset), .portIn(portIn), .portWakeEn(portWakeEn),
    .irqReq(irqReq), .irqEn(irqEn), .stackFull(stackFull),
    .sysClkEn(sysClkEn), .inSleep(inSleep), .inIdle(inIdle),
    .wdtClear(wdtClear), .wdtRun(wdtRun), .pdFlag(pdFlag), .toFlag(toFlag),
    .wakeFull(wakeFull), .wakePartial(wakePartial),
    .wakeVector(wakeVector), .wakeResume(wakeResume)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expectWake(input int kind);
    expQ.push_back(kind);
  endtask

  task automatic waitDrain(input string req);
    int guard = 0;
    while (expQ.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check({req, " command seen"}, expQ.size(), 0);
    expQ.delete();
    tick(2);
  endtask

  task automatic doHalt(input logic idle);
    @(negedge clk);
    idleMode = idle;
    haltReq = 1'b1;
    #1 clrSeen = wdtClear;
    @(negedge clk);
    haltReq = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // monitor side: pops expected commands, checks kind and start-up timing
  always @(negedge clk) begin
    if (rstN) begin
      int kind;
      onCyc = sysClkEn ? onCyc + 1 : 0;
      kind = wakeFull ? K_FULL : wakePartial ? K_PART :
             wakeVector ? K_VEC : wakeResume ? K_RES : -1;
      if (kind >= 0) begin
        if (expQ.size() == 0) begin
          check("R8 unexpected wake command", kind, -1);
        end else begin
          int exp;
          exp = expQ.pop_front();
          check("R8/R11 wake command kind", kind, exp);
          check("R10 start-up cycles", onCyc, (exp == K_VEC) ? SC + 1 : SC);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    tick(3);
    rstN = 1'b1;
    tick(1);
    // R3 reset state
    check("R3 pdFlag after reset", pdFlag, 0);
    check("R3 toFlag after reset", toFlag, 0);
    check("R1 clock on after reset", sysClkEn, 1);

    // Sleep entry, port wake
    wdtFromSlow = 1'b1;
    doHalt(1'b0);
    check("R4 wdtClear at entry", clrSeen, 1);
    check("R1 clock off", sysClkEn, 0);
    check("R1 sleep", inSleep, 1);
    check("R2 pdFlag set", pdFlag, 1);
    check("R2 toFlag clear", toFlag, 0);
    check("R4 wdt runs on slow clock", wdtRun, 1);
    portWakeEn = 8'h01;
    portIn[3] = 1'b0;
    tick(10);
    check("R7 disabled pin ignored", sysClkEn, 0);
    pulse(haltReq);
    check("R1 halt while halted ignored", sysClkEn, 0);
    expectWake(K_RES);
    portIn[0] = 1'b0;
    waitDrain("R7");
    portIn = '1;
    tick(4);

    // Idle entry, system-clock watchdog, external reset
    wdtFromSlow = 1'b0;
    doHalt(1'b1);
    check("R4 no wdtClear from system clock", clrSeen, 0);
    check("R1 idle", inIdle, 1);
    check("R4 wdt stopped", wdtRun, 0);
    pulse(wdtOverflow);
    tick(5);
    check("R5 overflow ignored while stopped", sysClkEn, 0);
    check("R5 toFlag untouched", toFlag, 0);
    expectWake(K_FULL);
    pulse(extReset);
    waitDrain("R6");
    check("R6 pdFlag kept", pdFlag, 1);
    check("R6 toFlag kept", toFlag, 0);

    // R3 clear command
    pulse(clrWdtCmd);
    tick(1);
    check("R3 pdFlag cleared", pdFlag, 0);

    // watchdog wake from slow clock
    wdtFromSlow = 1'b1;
    doHalt(1'b0);
    expectWake(K_PART);
    pulse(wdtOverflow);
    waitDrain("R5");
    check("R5 toFlag set", toFlag, 1);

    // interrupt pending at entry cannot wake; fresh one vectors
    irqEn = 4'b0100;
    irqReq[1] = 1'b1;
    doHalt(1'b0);
    check("R2 toFlag cleared at entry", toFlag, 0);
    tick(10);
    check("R9 pending request ignored", sysClkEn, 0);
    expectWake(K_VEC);
    @(negedge clk);
    irqReq[2] = 1'b1;
    waitDrain("R8 vector");
    irqReq = '0;
    tick(2);

    // disabled interrupt resumes
    irqEn = '0;
    doHalt(1'b0);
    expectWake(K_RES);
    @(negedge clk);
    irqReq[0] = 1'b1;
    waitDrain("R8 disabled");
    irqReq = '0;
    tick(2);

    // stack full resumes
    irqEn = '1;
    stackFull = 1'b1;
    doHalt(1'b0);
    expectWake(K_RES);
    @(negedge clk);
    irqReq[3] = 1'b1;
    waitDrain("R8 stack full");
    irqReq = '0;
    stackFull = 1'b0;
    tick(2);

    // R11 precedence: reset beats watchdog
    doHalt(1'b0);
    expectWake(K_FULL);
    @(negedge clk);
    extReset = 1'b1;
    wdtOverflow = 1'b1;
    @(negedge clk);
    extReset = 1'b0;
    wdtOverflow = 1'b0;
    waitDrain("R11 reset first");
    check("R11 toFlag not set by losing overflow", toFlag, 0);

    // R11 precedence: watchdog beats interrupt
    doHalt(1'b0);
    expectWake(K_PART);
    @(negedge clk);
    wdtOverflow = 1'b1;
    irqReq[0] = 1'b1;
    @(negedge clk);
    wdtOverflow = 1'b0;
    waitDrain("R11 watchdog second");
    irqReq = '0;
    tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule